// File: doc/BRIEF.md
# Floppy Descriptor Chain Sequencer

This block runs a floppy-disk controller from a linked list of command descriptors kept in word-addressed memory. A fixed four-word control area holds the pointer to the current descriptor and a notify mask. After a start pulse, the sequencer reads that pointer and processes one descriptor at a time. For each one it resets controller attention, reads the buffer address, length and control word, and hands a chain of command and parameter words to a register-load unit. It then runs a no-op, a seek or a DMA transfer, as selected by the control word.

When the operation is over, it collects three status sources into one result word. It writes the address, length and result back into the descriptor, copies the descriptor's link word into the control area as the new current pointer, and pulses notify. When the pointer it reads is zero, it clears the wake enables and goes idle. While idle it issues no requests of any kind.

Top module: `fdc_chain_seq`

## Requirements
- R1: After reset, busy, notify, mem_req, ld_req and exec_req are all low, and they stay low while the block is idle and start is low.
- R2: A start pulse while idle makes the block read control-area word 0 (the descriptor pointer) and word 3 (the notify mask). If the pointer is zero, the block issues exactly a loader attention reset (ld_op 0) followed by a wake-enable write (ld_op 1) of 0. It then returns idle with no notify.
- R3: For each descriptor, the block first issues an attention reset and then a wake-enable write of 5. It then reads descriptor words 4 (address low half), 5 (address high half), 6 (length) and 8 (control word).
- R4: Control-word bits 11:8 give the word offset of the first register load, and 0 means none. Each load word is read from the descriptor at that offset and passed to the loader with ld_op 2. The next offset is taken from bits 11:8 of that load word. The chain stops at an offset of 0 or after MAX_LOADS loads.
- R5: After the loads, the block writes control-word bits 3:0 to the wake enables (ld_op 1).
- R6: Control-word bits 15:12 select the operation: 4 is a seek (exec_kind 1), 8 is a DMA read (exec_kind 2) and 12 is a DMA write (exec_kind 3). exec_req holds the buffer address and length stable until exec_done. A DMA takes the address and length returned with exec_done for write-back, while a seek keeps the original values. After the operation, the block writes 5 to the wake enables.
- R7: Any other dispatch code, including 0, raises no exec_req. Such a descriptor only collects status.
- R8: Result bits 3:0 are the low 4 bits of the controller-status read (ld_op 3). Result bits 15:11 are the low 5 bits of a result read (ld_op 5), taken only when a chip-status read (ld_op 4) shows bit 4 set; otherwise these bits are 0.
- R9: The block issues a drive-status command (ld_op 6). It then repeats chip-status reads while bit 7 is set, and places the low 7 bits of the following result read in result bits 10:4.
- R10: On completion, the block writes descriptor words 4, 5, 6 and 7 with the address halves, the length and the result. It then reads word 0 (the link) and writes that value into control-area word 0.
- R11: notify is a one-cycle pulse, with notify_mask equal to the mask that was read. The block then goes on to the next descriptor until the pointer is zero.
- R12: A start pulse while busy has no effect on the sequence of requests.
- R13: A memory request holds its address, direction and write data stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Wake request from software |
| busy | output | 1 | High while not idle |
| notify | output | 1 | Completion pulse, one cycle |
| notify_mask | output | 16 | Mask read from control-area word 3 |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 16 | Read data |
| ld_req | output | 1 | Loader request, held until acknowledged |
| ld_op | output | 3 | Loader operation code |
| ld_wdata | output | 16 | Word for load or wake-enable write |
| ld_ack | input | 1 | Loader done; read data valid |
| ld_rdata | input | 8 | Byte read from the controller |
| exec_req | output | 1 | Execution-phase request |
| exec_kind | output | 2 | 1 seek, 2 DMA read, 3 DMA write |
| exec_addr | output | 32 | Buffer word address |
| exec_len | output | 16 | Buffer length in words |
| exec_done | input | 1 | Execution phase finished |
| exec_addr_end | input | 32 | Address after transfer |
| exec_len_end | input | 16 | Length left after transfer |

## Verification
The completion notify for one descriptor and the memory read of the control-area pointer for the next one fall in the same cycle. The link write-back hands straight over to the next fetch. A multi-descriptor chain provokes this on every completion. A monitor judges each notify cycle by requiring a read request at control-area word 0 alongside it. A start pulse is also placed in the middle of a chain, and the bench judges its effect by the exact count of attention resets and notifies.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    localparam int WORD_W = 16;
    localparam int BA_W   = 32;
    localparam int BYTE_W = 8;

    // descriptor word offsets
    localparam int OFS_LINK  = 0;
    localparam int OFS_BA_LO = 4;
    localparam int OFS_BA_HI = 5;
    localparam int OFS_LEN   = 6;
    localparam int OFS_RES   = 7;
    localparam int OFS_CTRL  = 8;
    // control-area word offsets
    localparam int CSB_PTR   = 0;
    localparam int CSB_MASK  = 3;

    localparam logic [3:0] CMD_WAKE = 4'h5;
    localparam int BIT_RES_FULL = 4;
    localparam int BIT_CMD_BUSY = 7;

    // result word fields
    localparam int CST_LSB = 0;
    localparam int CST_W   = 4;
    localparam int DRV_LSB = 4;
    localparam int DRV_W   = 7;
    localparam int STD_LSB = 11;
    localparam int STD_W   = 5;

    typedef enum logic [2:0] {
        LD_ATTN = 3'd0, LD_WAKE = 3'd1, LD_LOAD = 3'd2, LD_RD_CTRL = 3'd3,
        LD_RD_CHIP = 3'd4, LD_RD_RESULT = 3'd5, LD_DRV_CMD = 3'd6
    } ld_op_t;

    typedef enum logic [1:0] {
        EX_NONE = 2'd0, EX_SEEK = 2'd1, EX_READ = 2'd2, EX_WRITE = 2'd3
    } ex_kind_t;

    typedef enum logic [4:0] {
        S_IDLE, S_PTR, S_MASK, S_ATTN, S_CWAKE, S_BALO, S_BAHI, S_LEN,
        S_CTRL, S_LDRD, S_LDWR, S_XWAKE, S_EXEC, S_PWAKE, S_CST, S_CHIP,
        S_STD, S_DCMD, S_DPOLL, S_DRD, S_WBLO, S_WBHI, S_WBLEN, S_WBRES,
        S_LINK, S_CSBW, S_STOP
    } seq_state_t;

    typedef struct packed {
        logic [3:0] func;
        logic [3:0] first;
        logic [3:0] spare;
        logic [3:0] wake;
    } ctrl_word_t;

    function automatic ex_kind_t func_to_kind(input logic [3:0] f);
        case (f)
            4'd4:    return EX_SEEK;
            4'd8:    return EX_READ;
            4'd12:   return EX_WRITE;
            default: return EX_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fdc_status_merge.sv
module fdc_status_merge
    import fdc_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      cap_ctrl,
    input  logic                      cap_std,
    input  logic                      cap_drv,
    input  logic [DRV_W-1:0]          din,
    output logic [WORD_W-1:0]         result
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            result <= '0;
        end else begin
            if (cap_ctrl) result[CST_LSB +: CST_W] <= din[CST_W-1:0];
            if (cap_std)  result[STD_LSB +: STD_W] <= din[STD_W-1:0];
            if (cap_drv)  result[DRV_LSB +: DRV_W] <= din[DRV_W-1:0];
        end
    end

    // a drive-status capture leaves the controller-status field alone
    assert_field_isolation_R9: assert property (@(posedge clk) disable iff (rst)
        (cap_drv && !clr && !cap_ctrl) |=> $stable(result[CST_LSB +: CST_W]));

endmodule

// File: rtl/fdc_seq_ctrl.sv
module fdc_seq_ctrl
    import fdc_seq_pkg::*;
#(
    parameter logic [15:0] CSB_BASE  = 16'h0008,
    parameter int          MAX_LOADS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              notify,
    output logic [WORD_W-1:0] notify_mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ld_req,
    output logic [2:0]        ld_op,
    output logic [WORD_W-1:0] ld_wdata,
    input  logic              ld_ack,
    input  logic              chip_res_full,
    input  logic              chip_cmd_busy,
    output logic              exec_req,
    output logic [1:0]        exec_kind,
    output logic [BA_W-1:0]   exec_addr,
    output logic [WORD_W-1:0] exec_len,
    input  logic              exec_done,
    input  logic [BA_W-1:0]   exec_addr_end,
    input  logic [WORD_W-1:0] exec_len_end,
    output logic              st_clr,
    output logic              st_cap_ctrl,
    output logic              st_cap_std,
    output logic              st_cap_drv,
    input  logic [WORD_W-1:0] result
);

    localparam int CNT_W = $clog2(MAX_LOADS + 1);

    seq_state_t        state;
    logic [15:0]       ptr, link;
    logic [BA_W-1:0]   ba;
    logic [WORD_W-1:0] len, ldw;
    logic [3:0]        func_q, wake_q, off;
    logic [CNT_W-1:0]  ldcnt;
    ld_op_t            op;
    ex_kind_t          kind;
    ctrl_word_t        cw_in;

    assign cw_in       = ctrl_word_t'(mem_rdata);
    assign kind        = func_to_kind(func_q);
    assign busy        = (state != S_IDLE);
    assign ld_op       = op;
    assign exec_kind   = kind;
    assign exec_addr   = ba;
    assign exec_len    = len;
    assign st_clr      = (state == S_ATTN)  && ld_ack;
    assign st_cap_ctrl = (state == S_CST)   && ld_ack;
    assign st_cap_std  = (state == S_STD)   && ld_ack;
    assign st_cap_drv  = (state == S_DRD)   && ld_ack;

    // request generation
    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        ld_req = 1'b0; op = LD_ATTN; ld_wdata = '0;
        exec_req = 1'b0;
        case (state)
            S_PTR:   begin mem_req = 1'b1; mem_addr = CSB_BASE + 16'(CSB_PTR); end
            S_MASK:  begin mem_req = 1'b1; mem_addr = CSB_BASE + 16'(CSB_MASK); end
            S_ATTN:  begin ld_req = 1'b1; op = LD_ATTN; end
            S_CWAKE: begin ld_req = 1'b1; op = LD_WAKE; ld_wdata = {12'h000, CMD_WAKE}; end
            S_BALO:  begin mem_req = 1'b1; mem_addr = ptr + 16'(OFS_BA_LO); end
            S_BAHI:  begin mem_req = 1'b1; mem_addr = ptr + 16'(OFS_BA_HI); end
            S_LEN:   begin mem_req = 1'b1; mem_addr = ptr + 16'(OFS_LEN); end
            S_CTRL:  begin mem_req = 1'b1; mem_addr = ptr + 16'(OFS_CTRL); end
            S_LDRD:  begin mem_req = 1'b1; mem_addr = ptr + {12'h000, off}; end
            S_LDWR:  begin ld_req = 1'b1; op = LD_LOAD; ld_wdata = ldw; end
            S_XWAKE: begin ld_req = 1'b1; op = LD_WAKE; ld_wdata = {12'h000, wake_q}; end
            S_EXEC:  exec_req = 1'b1;
            S_PWAKE: begin ld_req = 1'b1; op = LD_WAKE; ld_wdata = {12'h000, CMD_WAKE}; end
            S_CST:   begin ld_req = 1'b1; op = LD_RD_CTRL; end
            S_CHIP, S_DPOLL: begin ld_req = 1'b1; op = LD_RD_CHIP; end
            S_STD, S_DRD:    begin ld_req = 1'b1; op = LD_RD_RESULT; end
            S_DCMD:  begin ld_req = 1'b1; op = LD_DRV_CMD; end
            S_WBLO:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr + 16'(OFS_BA_LO); mem_wdata = ba[15:0]; end
            S_WBHI:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr + 16'(OFS_BA_HI); mem_wdata = ba[31:16]; end
            S_WBLEN: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr + 16'(OFS_LEN); mem_wdata = len; end
            S_WBRES: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr + 16'(OFS_RES); mem_wdata = result; end
            S_LINK:  begin mem_req = 1'b1; mem_addr = ptr + 16'(OFS_LINK); end
            S_CSBW:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = CSB_BASE + 16'(CSB_PTR); mem_wdata = link; end
            S_STOP:  begin ld_req = 1'b1; op = LD_WAKE; end
            default: ;
        endcase
    end

    // sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; notify <= 1'b0; notify_mask <= '0;
            ptr <= '0; link <= '0; ba <= '0; len <= '0; ldw <= '0;
            func_q <= '0; wake_q <= '0; off <= '0; ldcnt <= '0;
        end else begin
            notify <= 1'b0;
            case (state)
                S_IDLE:  if (start) state <= S_PTR;
                S_PTR:   if (mem_ack) begin ptr <= mem_rdata; state <= S_MASK; end
                S_MASK:  if (mem_ack) begin notify_mask <= mem_rdata; state <= S_ATTN; end
                S_ATTN:  if (ld_ack) state <= (ptr == '0) ? S_STOP : S_CWAKE;
                S_CWAKE: if (ld_ack) state <= S_BALO;
                S_BALO:  if (mem_ack) begin ba[15:0] <= mem_rdata; state <= S_BAHI; end
                S_BAHI:  if (mem_ack) begin ba[31:16] <= mem_rdata; state <= S_LEN; end
                S_LEN:   if (mem_ack) begin len <= mem_rdata; state <= S_CTRL; end
                S_CTRL:  if (mem_ack) begin
                    func_q <= cw_in.func; wake_q <= cw_in.wake;
                    off <= cw_in.first; ldcnt <= '0;
                    state <= (cw_in.first == 4'h0) ? S_XWAKE : S_LDRD;
                end
                S_LDRD:  if (mem_ack) begin ldw <= mem_rdata; state <= S_LDWR; end
                S_LDWR:  if (ld_ack) begin
                    off   <= ldw[11:8];
                    ldcnt <= ldcnt + 1'b1;
                    state <= (ldw[11:8] == 4'h0 || ldcnt + 1'b1 == CNT_W'(MAX_LOADS))
                             ? S_XWAKE : S_LDRD;
                end
                S_XWAKE: if (ld_ack) state <= (kind != EX_NONE) ? S_EXEC : S_CST;
                S_EXEC:  if (exec_done) begin
                    if (kind == EX_READ || kind == EX_WRITE) begin
                        ba  <= exec_addr_end;
                        len <= exec_len_end;
                    end
                    state <= S_PWAKE;
                end
                S_PWAKE: if (ld_ack) state <= S_CST;
                S_CST:   if (ld_ack) state <= S_CHIP;
                S_CHIP:  if (ld_ack) state <= chip_res_full ? S_STD : S_DCMD;
                S_STD:   if (ld_ack) state <= S_DCMD;
                S_DCMD:  if (ld_ack) state <= S_DPOLL;
                S_DPOLL: if (ld_ack && !chip_cmd_busy) state <= S_DRD;
                S_DRD:   if (ld_ack) state <= S_WBLO;
                S_WBLO:  if (mem_ack) state <= S_WBHI;
                S_WBHI:  if (mem_ack) state <= S_WBLEN;
                S_WBLEN: if (mem_ack) state <= S_WBRES;
                S_WBRES: if (mem_ack) state <= S_LINK;
                S_LINK:  if (mem_ack) begin link <= mem_rdata; state <= S_CSBW; end
                S_CSBW:  if (mem_ack) begin notify <= 1'b1; state <= S_PTR; end
                S_STOP:  if (ld_ack) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !ld_req && !exec_req));
    assert_mem_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    assert_exec_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (exec_req && !exec_done) |=> (exec_req && $stable(exec_addr) && $stable(exec_len)));
    assert_exec_legal_R7: assert property (@(posedge clk) disable iff (rst)
        exec_req |-> (exec_kind != 2'(EX_NONE)));
    assert_notify_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        notify |=> !notify);
    assert_notify_after_link_R10: assert property (@(posedge clk) disable iff (rst)
        notify |-> $past(mem_req && mem_we && mem_ack && mem_addr == CSB_BASE));
    assert_one_port_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, ld_req, exec_req}));

endmodule

// File: rtl/fdc_chain_seq.sv
module fdc_chain_seq
    import fdc_seq_pkg::*;
#(
    parameter logic [15:0] CSB_BASE  = 16'h0008,
    parameter int          MAX_LOADS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              notify,
    output logic [15:0]       notify_mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              ld_req,
    output logic [2:0]        ld_op,
    output logic [15:0]       ld_wdata,
    input  logic              ld_ack,
    input  logic [7:0]        ld_rdata,
    output logic              exec_req,
    output logic [1:0]        exec_kind,
    output logic [31:0]       exec_addr,
    output logic [15:0]       exec_len,
    input  logic              exec_done,
    input  logic [31:0]       exec_addr_end,
    input  logic [15:0]       exec_len_end
);

    logic              st_clr, st_cap_ctrl, st_cap_std, st_cap_drv;
    logic [WORD_W-1:0] result;

    fdc_seq_ctrl #(.CSB_BASE(CSB_BASE), .MAX_LOADS(MAX_LOADS)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .notify(notify), .notify_mask(notify_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ld_req(ld_req), .ld_op(ld_op), .ld_wdata(ld_wdata), .ld_ack(ld_ack),
        .chip_res_full(ld_rdata[BIT_RES_FULL]), .chip_cmd_busy(ld_rdata[BIT_CMD_BUSY]),
        .exec_req(exec_req), .exec_kind(exec_kind), .exec_addr(exec_addr),
        .exec_len(exec_len), .exec_done(exec_done),
        .exec_addr_end(exec_addr_end), .exec_len_end(exec_len_end),
        .st_clr(st_clr), .st_cap_ctrl(st_cap_ctrl), .st_cap_std(st_cap_std),
        .st_cap_drv(st_cap_drv), .result(result)
    );

    fdc_status_merge u_stat (
        .clk(clk), .rst(rst), .clr(st_clr),
        .cap_ctrl(st_cap_ctrl), .cap_std(st_cap_std), .cap_drv(st_cap_drv),
        .din(ld_rdata[DRV_W-1:0]), .result(result)
    );

endmodule

// File: tb/fdc_chain_seq_bench.sv
module fdc_chain_seq_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] CSB        = 16'h0008;
    localparam int          MAXL       = 6;
    localparam int          NVEC       = 5;
    // ctrl16 | full1 | std5 | drv7 | cst4 | polls4
    localparam logic [36:0] VEC [0:NVEC-1] = '{
        {16'h0003, 1'b1, 5'h15, 7'h2A, 4'h9, 4'd0},
        {16'h4205, 1'b0, 5'h1F, 7'h7F, 4'h3, 4'd2},
        {16'h8A0C, 1'b1, 5'h01, 7'h00, 4'hF, 4'd3},
        {16'hC90A, 1'b1, 5'h1F, 7'h55, 4'h0, 4'd1},
        {16'h2001, 1'b0, 5'h0A, 7'h11, 4'h6, 4'd0}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic busy, notify, mem_req, mem_we, mem_ack, ld_req, ld_ack, exec_req, exec_done;
    logic [15:0] notify_mask, mem_addr, mem_wdata, mem_rdata, ld_wdata, exec_len, exec_len_end;
    logic [2:0]  ld_op;
    logic [7:0]  ld_rdata;
    logic [1:0]  exec_kind;
    logic [31:0] exec_addr, exec_addr_end;

    fdc_chain_seq #(.CSB_BASE(CSB), .MAX_LOADS(MAXL)) u_fdc_chain_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .notify(notify),
        .notify_mask(notify_mask), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .ld_req(ld_req), .ld_op(ld_op), .ld_wdata(ld_wdata),
        .ld_ack(ld_ack), .ld_rdata(ld_rdata), .exec_req(exec_req),
        .exec_kind(exec_kind), .exec_addr(exec_addr), .exec_len(exec_len),
        .exec_done(exec_done), .exec_addr_end(exec_addr_end), .exec_len_end(exec_len_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory: setup image from the test, DUT writes in a shadow
    logic [15:0] img [0:255];
    logic [15:0] wmem [0:255];
    logic        wval [0:255];
    logic        wclr = 1'b0;
    int          mem_wr_n = 0;

    function automatic logic [15:0] rd(input int a);
        return wval[a] ? wmem[a] : img[a];
    endfunction

    always @(posedge clk) begin
        if (wclr) for (int i = 0; i < 256; i++) wval[i] <= 1'b0;
        if (rst) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= rd(int'(mem_addr[7:0]));
            if (mem_we) begin
                wmem[mem_addr[7:0]] <= mem_wdata;
                wval[mem_addr[7:0]] <= 1'b1;
                mem_wr_n <= mem_wr_n + 1;
            end
        end else mem_ack <= 1'b0;
    end

    // loader model
    logic [3:0] cfg_cst = '0, cfg_polls = '0;
    logic       cfg_full = 1'b0;
    logic [4:0] cfg_std = '0;
    logic [6:0] cfg_drv = '0;
    logic       drv_pend;
    int         busy_left;
    logic [2:0]  lg_op  [0:1023];
    logic [15:0] lg_dat [0:1023];
    int          lg_n = 0;

    always @(posedge clk) begin
        if (rst) begin ld_ack <= 1'b0; drv_pend <= 1'b0; busy_left <= 0; ld_rdata <= '0; end
        else if (ld_req && !ld_ack) begin
            ld_ack <= 1'b1;
            lg_op[lg_n[9:0]]  <= ld_op;
            lg_dat[lg_n[9:0]] <= ld_wdata;
            lg_n <= lg_n + 1;
            case (ld_op)
                3'd3: ld_rdata <= {4'hA, cfg_cst};
                3'd4: if (drv_pend && busy_left > 0) begin
                          ld_rdata <= 8'h80; busy_left <= busy_left - 1;
                      end else ld_rdata <= 8'h60 | ((cfg_full && !drv_pend) ? 8'h10 : 8'h00);
                3'd5: if (drv_pend) begin ld_rdata <= {1'b1, cfg_drv}; drv_pend <= 1'b0; end
                      else ld_rdata <= {3'b111, cfg_std};
                3'd6: begin drv_pend <= 1'b1; busy_left <= int'(cfg_polls); end
                default: ld_rdata <= 8'h00;
            endcase
        end else ld_ack <= 1'b0;
    end

    // execution-phase model
    int          ex_n = 0;
    logic [1:0]  ex_kind_l;
    logic [31:0] ex_addr_l;
    logic [15:0] ex_len_l;
    always @(posedge clk) begin
        if (rst) exec_done <= 1'b0;
        else if (exec_req && !exec_done) begin
            exec_done     <= 1'b1;
            exec_addr_end <= exec_addr + {16'h0, exec_len};
            exec_len_end  <= 16'h0000;
            ex_kind_l <= exec_kind; ex_addr_l <= exec_addr; ex_len_l <= exec_len;
            ex_n <= ex_n + 1;
        end else exec_done <= 1'b0;
    end

    // notify monitor: notify must coincide with the next pointer fetch
    int          nt_n = 0, mon_checks = 0, mon_fails = 0;
    logic [15:0] nt_mask;
    always @(negedge clk) begin
        if (!rst && notify) begin
            nt_n <= nt_n + 1;
            nt_mask <= notify_mask;
            mon_checks <= mon_checks + 1;
            if (!(mem_req && !mem_we && mem_addr == CSB)) begin
                mon_fails <= mon_fails + 1;
                $display("FAIL R11 notify cycle: actual req=%b we=%b addr=%h expected read of %h",
                         mem_req, mem_we, mem_addr, CSB);
            end
        end
    end

    int checks = 0, fails = 0, cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                     checks + mon_checks + 1, fails + mon_fails + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_desc(input int base, input logic [15:0] link, ctrl, lo, hi, len);
        for (int k = 0; k < 16; k++)
            img[base+k] = {4'hD, (k == 10) ? 4'hB : 4'h0, 4'h0, 4'(k)};
        img[base]   = link;
        img[base+4] = lo;
        img[base+5] = hi;
        img[base+6] = len;
        img[base+7] = 16'hDEAD;
        img[base+8] = ctrl;
    endtask

    task automatic clear_writes();
        @(negedge clk) wclr = 1'b1;
        @(negedge clk) wclr = 1'b0;
    endtask

    task automatic kick_and_wait();
        int t;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        t = 0;
        while (busy && t < 20000) begin @(negedge clk); t++; end
        chk("R11 sequence completes", {31'h0, busy}, 32'h0);
    endtask

    function automatic logic [1:0] kind_of(input logic [3:0] f);
        case (f) 4'd4: return 2'd1; 4'd8: return 2'd2; 4'd12: return 2'd3; default: return 2'd0; endcase
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin img[i] = 16'h0000; wval[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'h0, busy}, 0);
        chk("R1 notify", {31'h0, notify}, 0);
        chk("R1 requests", {29'h0, mem_req, ld_req, exec_req}, 0);

        // R2 empty list
        begin
            int b = lg_n, n0 = nt_n, w0 = mem_wr_n;
            img[CSB] = 16'h0000; img[CSB+3] = 16'h0077;
            kick_and_wait();
            chk("R2 loader op count", lg_n - b, 2);
            chk("R2 first op attn", {29'h0, lg_op[b]}, 0);
            chk("R2 wake op", {29'h0, lg_op[b+1]}, 1);
            chk("R2 wake cleared", {16'h0, lg_dat[b+1]}, 0);
            chk("R2 no notify", nt_n - n0, 0);
            chk("R2 no memory write", mem_wr_n - w0, 0);
        end

        // table walk, one descriptor each
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] ctrl, lo, hi, len, res_exp, mask;
            logic [31:0] ba_exp; logic [15:0] len_exp;
            logic [15:0] exl [0:7];
            int nl, off, b, e0, n0, p;
            ctrl = VEC[v][36:21];
            cfg_full = VEC[v][20]; cfg_std = VEC[v][19:15]; cfg_drv = VEC[v][14:8];
            cfg_cst = VEC[v][7:4]; cfg_polls = VEC[v][3:0];
            lo = 16'hFFF0 + 16'(v); hi = 16'h0002 + 16'(v); len = 16'h0020 + 16'(v);
            mask = 16'h1000 + 16'(v);
            clear_writes();
            load_desc(64, 16'h0000, ctrl, lo, hi, len);
            img[CSB] = 16'd64; img[CSB+3] = mask;
            nl = 0; off = int'(ctrl[11:8]);
            while (off != 0 && nl < MAXL) begin
                exl[nl] = img[64+off]; off = int'(exl[nl][11:8]); nl++;
            end
            b = lg_n; e0 = ex_n; n0 = nt_n;
            kick_and_wait();
            res_exp = {cfg_full ? cfg_std : 5'h00, cfg_drv, cfg_cst};
            if (kind_of(ctrl[15:12]) == 2'd2 || kind_of(ctrl[15:12]) == 2'd3) begin
                ba_exp = {hi, lo} + {16'h0, len}; len_exp = 16'h0;
            end else begin
                ba_exp = {hi, lo}; len_exp = len;
            end
            chk("R3 attn first", {29'h0, lg_op[b]}, 0);
            chk("R3 command wake", {13'h0, lg_op[b+1], lg_dat[b+1]}, {13'h0, 3'd1, 16'h0005});
            for (int i = 0; i < nl; i++)
                chk("R4 load word", {13'h0, lg_op[b+2+i], lg_dat[b+2+i]}, {13'h0, 3'd2, exl[i]});
            chk("R5 exec wake", {13'h0, lg_op[b+2+nl], lg_dat[b+2+nl]}, {13'h0, 3'd1, 12'h0, ctrl[3:0]});
            p = b + 3 + nl;
            if (kind_of(ctrl[15:12]) != 2'd0) begin
                chk("R6 exec count", ex_n - e0, 1);
                chk("R6 exec kind", {30'h0, ex_kind_l}, {30'h0, kind_of(ctrl[15:12])});
                chk("R6 exec addr", ex_addr_l, {hi, lo});
                chk("R6 exec len", {16'h0, ex_len_l}, {16'h0, len});
                chk("R6 post wake", {13'h0, lg_op[p], lg_dat[p]}, {13'h0, 3'd1, 16'h0005});
            end else begin
                chk("R7 no exec", ex_n - e0, 0);
                chk("R7 status read next", {29'h0, lg_op[p]}, 3);
            end
            chk("R8 R9 result word", {16'h0, rd(71)}, {16'h0, res_exp});
            chk("R10 address low", {16'h0, rd(68)}, {16'h0, ba_exp[15:0]});
            chk("R10 address high", {16'h0, rd(69)}, {16'h0, ba_exp[31:16]});
            chk("R10 length", {16'h0, rd(70)}, {16'h0, len_exp});
            chk("R10 list head", {16'h0, rd(int'(CSB))}, 0);
            chk("R11 notify count", nt_n - n0, 1);
            chk("R11 notify mask", {16'h0, nt_mask}, {16'h0, mask});
            chk("R2 stop wake", {13'h0, lg_op[lg_n-1], lg_dat[lg_n-1]}, {13'h0, 3'd1, 16'h0});
        end

        // load chain capped at MAXL: a word that points back at itself
        begin
            int b, cnt;
            cfg_full = 1'b0; cfg_polls = 4'd0;
            clear_writes();
            load_desc(64, 16'h0000, 16'h0900, 16'h0100, 16'h0000, 16'h0004);
            img[64+9] = 16'hD909;
            img[CSB] = 16'd64;
            b = lg_n;
            kick_and_wait();
            cnt = 0;
            for (int i = b; i < lg_n; i++) if (lg_op[i] == 3'd2) cnt++;
            chk("R4 load cap", cnt, MAXL);
            chk("R4 capped word", {16'h0, lg_dat[b+2]}, 32'h0000D909);
        end

        // three-descriptor chain with a start pulse in the middle
        begin
            int b, n0, attn, t;
            cfg_full = 1'b1; cfg_std = 5'h0C; cfg_drv = 7'h33; cfg_cst = 4'h5; cfg_polls = 4'd1;
            clear_writes();
            load_desc(64, 16'd96, 16'h8000, 16'h0010, 16'h0000, 16'h0008);
            load_desc(96, 16'd128, 16'h4000, 16'h0200, 16'h0000, 16'h0008);
            load_desc(128, 16'h0000, 16'h0000, 16'h0300, 16'h0000, 16'h0008);
            img[CSB] = 16'd64; img[CSB+3] = 16'hBEEF;
            b = lg_n; n0 = nt_n;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (40) @(negedge clk);
            chk("R12 busy before stray start", {31'h0, busy}, 1);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            t = 0;
            while (busy && t < 20000) begin @(negedge clk); t++; end
            chk("R12 chain completes", {31'h0, busy}, 0);
            attn = 0;
            for (int i = b; i < lg_n; i++) if (lg_op[i] == 3'd0) attn++;
            chk("R12 attention resets", attn, 4);
            chk("R11 chain notifies", nt_n - n0, 3);
            chk("R10 first result", {16'h0, rd(71)}, {16'h0, 5'h0C, 7'h33, 4'h5});
            chk("R10 second result", {16'h0, rd(103)}, {16'h0, 5'h0C, 7'h33, 4'h5});
            chk("R10 third result", {16'h0, rd(135)}, {16'h0, 5'h0C, 7'h33, 4'h5});
            chk("R6 DMA address written", {16'h0, rd(68)}, 32'h00000018);
            chk("R6 seek address kept", {16'h0, rd(100)}, 32'h00000200);
            chk("R10 head empty", {16'h0, rd(int'(CSB))}, 0);
            // idle quiet
            b = lg_n;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (mem_req || ld_req || exec_req) chk("R1 idle quiet", 1, 0);
            end
            chk("R1 no loader traffic while idle", lg_n - b, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule